// File: doc/BRIEF.md
# Asynchronous DRAM Controller with CAS-before-RAS Refresh

This block lets a 16-bit asynchronous processor bus reach two banks of page-less asynchronous DRAM. The controller runs on its own fast clock. That clock has no fixed relation to the processor clock. Chip-select and address-strobe cross into the controller domain through two flip-flop stages. Address, read/write, bank select and the two data strobes are held steady by the processor for the whole bus cycle, so they are sampled directly.

An access walks through a chain of small states. Each state changes one thing: row address out, RAS low, column address and write-enable, byte-lane CAS, then the data acknowledge. The acknowledge stays low until the processor lifts its address strobe, so the processor decides how long an access lasts. A free-running timer asks for a CAS-before-RAS refresh of both banks at a fixed interval. The idle state serves a pending refresh ahead of any new access. Every access and every refresh ends in a precharge state, which holds all strobes high for a set number of clocks.

Top module: `dram_ctl`

## Requirements
- R1: While reset is asserted, and right after it is released, all RAS, CAS and write-enable outputs and `dtack_n` are high.
- R2: An access begins only when both the synchronized `cpu_cs_n` and `cpu_as_n` are low. With only one of the two low, no RAS falls and `dtack_n` stays high.
- R3: With the bus idle, consecutive refresh cycles (both RAS falling together) are exactly `REFRESH_CYCLES` (default 781) controller clocks apart.
- R4: A refresh lowers all four CAS lines one clock before both RAS lines fall. All CAS rise one clock after RAS falls, and both RAS rise one clock after that.
- R5: Both write-enables are high at the clock where the refresh RAS falls.
- R6: An access and a refresh never overlap. A refresh never starts while `dtack_n` is low, and an access RAS never falls while any CAS is low. Under processor traffic the spacing between refreshes never exceeds `REFRESH_CYCLES` plus the longest access plus a few clocks.
- R7: `bank_sel` = 0 selects bank 0 (`ras_n[0]`) and 1 selects bank 1 (`ras_n[1]`). Only the selected bank's RAS falls. While it falls, `dram_addr` carries `cpu_addr[11:1]`.
- R8: When the access CAS falls, `dram_addr` carries `cpu_addr[22:12]`. The selected bank's write-enable equals `cpu_rw` (1 = read, 0 = write) and the other write-enable is high.
- R9: Within a bank b, `cas_n[2b]` is the lower byte lane and follows `cpu_lds_n`. `cas_n[2b+1]` is the upper lane and follows `cpu_uds_n`. Only lanes whose data strobe is low get a falling CAS.
- R10: `dtack_n` falls after CAS has been driven. It stays low for as long as the address strobe stays low. When it rises, all RAS, CAS and write-enable lines are high.
- R11: After any RAS rises, RAS stays high for at least `PRECHARGE_CYCLES` (default 2) clocks before either RAS falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, independent of the processor |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs_n | input | 1 | Memory chip select from the processor side, active low, asynchronous |
| cpu_as_n | input | 1 | Processor address strobe, active low, asynchronous |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_lds_n | input | 1 | Lower data strobe, active low |
| cpu_uds_n | input | 1 | Upper data strobe, active low |
| bank_sel | input | 1 | 0 = bank 0, 1 = bank 1 |
| cpu_addr | input | 2*ADDR_W (bits 22:1) | Processor word address |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| ras_n | output | 2 | Row strobe per bank, active low |
| cas_n | output | 4 | Column strobe per byte lane, {bank1 upper, bank1 lower, bank0 upper, bank0 lower} |
| we_n | output | 2 | Write-enable per bank, active low |
| dtack_n | output | 1 | Data acknowledge to the processor, active low |

## Verification
The bound checker watches the strobe relations on every clock. It checks that CAS leads RAS in a refresh and that write-enable is high when the refresh RAS falls. It checks that an access opens one bank only, that acknowledge appears only while exactly one row is open, and that RAS precharge holds for two clocks. Some behaviour only the bench scenarios can show, because it depends on the processor side and on long spans of time. That covers the exact refresh interval, the address and byte-lane mapping, acknowledge holding until the strobe rises, a lone chip-select or strobe being ignored, and the refresh spacing under traffic from a processor clock that never lines up with the controller clock.

// File: rtl/dram_ctl.sv
module dram_ctl #(
  parameter int ADDR_W           = 11,
  parameter int REFRESH_CYCLES   = 781,
  parameter int PRECHARGE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_cs_n,
  input  logic              cpu_as_n,
  input  logic              cpu_rw,
  input  logic              cpu_lds_n,
  input  logic              cpu_uds_n,
  input  logic              bank_sel,
  input  logic [2*ADDR_W:1] cpu_addr,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [1:0]        ras_n,
  output logic [3:0]        cas_n,
  output logic [1:0]        we_n,
  output logic              dtack_n
);

  localparam int TMR_W = $clog2(REFRESH_CYCLES);
  localparam int PRE_W = $clog2(PRECHARGE_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_REF1, S_REF2, S_REF3, S_REF4,
    S_ROW, S_RAS, S_COL, S_CAS, S_ACK, S_PRE
  } state_t;

  state_t             state;
  logic [1:0]         cs_sync, as_sync;
  logic [TMR_W-1:0]   tmr;
  logic               ref_req;
  logic [PRE_W-1:0]   pre_cnt;
  logic               bank_q;

  wire cs_s     = cs_sync[1];
  wire as_s     = as_sync[1];
  wire tick     = (tmr == TMR_W'(REFRESH_CYCLES - 1));
  wire ref_ack  = (state == S_REF1);
  wire pre_done = (pre_cnt == PRE_W'(PRECHARGE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync <= 2'b11;
      as_sync <= 2'b11;
    end else begin
      cs_sync <= {cs_sync[0], cpu_cs_n};
      as_sync <= {as_sync[0], cpu_as_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      ref_req <= 1'b0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick)         ref_req <= 1'b1;
      else if (ref_ack) ref_req <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      dram_addr <= '0;
      ras_n     <= 2'b11;
      cas_n     <= 4'hF;
      we_n      <= 2'b11;
      dtack_n   <= 1'b1;
      pre_cnt   <= '0;
      bank_q    <= 1'b0;
    end else begin
      pre_cnt <= '0;
      case (state)
        S_IDLE: begin
          if (ref_req)             state <= S_REF1;
          else if (!cs_s && !as_s) state <= S_ROW;
        end
        S_REF1: begin
          cas_n <= 4'h0;
          we_n  <= 2'b11;
          state <= S_REF2;
        end
        S_REF2: begin
          ras_n <= 2'b00;
          state <= S_REF3;
        end
        S_REF3: begin
          cas_n <= 4'hF;
          state <= S_REF4;
        end
        S_REF4: begin
          ras_n <= 2'b11;
          state <= S_PRE;
        end
        S_ROW: begin
          dram_addr <= cpu_addr[ADDR_W:1];
          bank_q    <= bank_sel;
          state     <= S_RAS;
        end
        S_RAS: begin
          ras_n[bank_q] <= 1'b0;
          state         <= S_COL;
        end
        S_COL: begin
          dram_addr    <= cpu_addr[2*ADDR_W:ADDR_W+1];
          we_n[bank_q] <= cpu_rw;
          state        <= S_CAS;
        end
        S_CAS: begin
          cas_n[{bank_q, 1'b0}] <= cpu_lds_n;
          cas_n[{bank_q, 1'b1}] <= cpu_uds_n;
          state                 <= S_ACK;
        end
        S_ACK: begin
          dtack_n <= 1'b0;
          if (as_s) state <= S_PRE;
        end
        S_PRE: begin
          ras_n   <= 2'b11;
          cas_n   <= 4'hF;
          we_n    <= 2'b11;
          dtack_n <= 1'b1;
          pre_cnt <= pre_cnt + 1'b1;
          if (pre_done) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ras_n,
  input logic [3:0] cas_n,
  input logic [1:0] we_n,
  input logic       dtack_n
);

  AST_CBR_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == 2'b00 && $past(ras_n) == 2'b11) |-> $past(cas_n) == 4'h0); // R4

  AST_CBR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == 2'b00 && $past(ras_n) == 2'b11) |-> we_n == 2'b11); // R5

  AST_ONE_BANK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ras_n) == 2'b11 && ras_n != 2'b11 && cas_n == 4'hF) |-> ras_n != 2'b00); // R7

  AST_ACK_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> $countones(ras_n) == 1); // R6

  AST_PRECHARGE_B0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |=> ras_n[0]); // R11

  AST_PRECHARGE_B1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[1]) |=> ras_n[1]); // R11

endmodule

bind dram_ctl dram_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .dtack_n(dtack_n)
);

// File: tb/tb_dram_ctl.sv
module tb_dram_ctl;
  localparam int CLK_PERIOD = 20;
  localparam int CPU_HALF   = 38;
  localparam int REF        = 781;
  localparam int PRE        = 2;

  logic clk, cpu_clk, rst_n;
  logic cpu_cs_n, cpu_as_n, cpu_rw, cpu_lds_n, cpu_uds_n, bank_sel;
  logic [22:1] cpu_addr;
  logic [10:0] dram_addr;
  logic [1:0]  ras_n, we_n;
  logic [3:0]  cas_n;
  logic        dtack_n;

  int checks = 0, fails = 0;

  dram_ctl dut (
    .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_as_n(cpu_as_n),
    .cpu_rw(cpu_rw), .cpu_lds_n(cpu_lds_n), .cpu_uds_n(cpu_uds_n),
    .bank_sel(bank_sel), .cpu_addr(cpu_addr), .dram_addr(dram_addr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dtack_n(dtack_n)
  );

  initial begin clk = 0; #5; forever #(CLK_PERIOD/2) clk = ~clk; end
  initial begin cpu_clk = 0; #2; forever #(CPU_HALF) cpu_clk = ~cpu_clk; end

  // Monitor state
  int cyc = 0, last_ref = -1, ref_count = 0, gap_last = 0, gap_max = 0;
  int ref_step = 0, hi_cnt = 100, acc_start = 0, acc_len_max = 0;
  int err_r4 = 0, err_r5 = 0, err_r6 = 0, err_r11 = 0;
  logic [1:0] prev_ras = 2'b11;
  logic [3:0] prev_cas = 4'hF;
  logic acc_valid = 0, acc_bank = 0;
  logic [10:0] acc_row = 0, acc_col = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ras_n != 2'b11 && prev_ras == 2'b11) begin
        if (hi_cnt < PRE) err_r11++;
      end
      if (ras_n == 2'b00 && prev_ras == 2'b11) begin
        if (prev_cas != 4'h0) err_r4++;
        if (we_n != 2'b11) err_r5++;
        if (!dtack_n) err_r6++;
        if (last_ref >= 0) begin
          gap_last = cyc - last_ref;
          if (gap_last > gap_max) gap_max = gap_last;
        end
        last_ref = cyc;
        ref_count++;
        ref_step = 1;
      end else if (ref_step == 1) begin
        if (!(cas_n == 4'hF && ras_n == 2'b00)) err_r4++;
        ref_step = 2;
      end else if (ref_step == 2) begin
        if (ras_n != 2'b11) err_r4++;
        ref_step = 0;
      end else if (prev_ras == 2'b11 && (ras_n == 2'b10 || ras_n == 2'b01)) begin
        if (cas_n != 4'hF) err_r6++;
        acc_row   = dram_addr;
        acc_bank  = (ras_n == 2'b01);
        acc_start = cyc;
        acc_valid = 1;
      end
      if (prev_cas == 4'hF && cas_n != 4'hF && (ras_n == 2'b10 || ras_n == 2'b01))
        acc_col = dram_addr;
      if ((prev_ras == 2'b10 || prev_ras == 2'b01) && ras_n == 2'b11)
        if (cyc - acc_start > acc_len_max) acc_len_max = cyc - acc_start;
      if (ras_n == 2'b11) hi_cnt = (prev_ras != 2'b11) ? 1 : hi_cnt + 1;
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    cpu_cs_n = 1; cpu_as_n = 1; cpu_rw = 1; cpu_lds_n = 1; cpu_uds_n = 1;
    bank_sel = 0; cpu_addr = '0;
    repeat (5) @(negedge clk);
    check(ras_n == 2'b11, "R1 ras", ras_n, 3);
    check(cas_n == 4'hF, "R1 cas", cas_n, 15);
    check(we_n == 2'b11 && dtack_n, "R1 we/dtack", {we_n, dtack_n}, 7);
    rst_n = 1;
    @(negedge clk);
    check(ras_n == 2'b11 && cas_n == 4'hF && dtack_n, "R1 after release",
          {ras_n, cas_n, dtack_n}, 8'h7F);
  endtask

  task automatic t_refresh_idle();
    while (ref_count < 3) @(negedge clk);
    check(gap_last == REF, "R3 idle refresh spacing", gap_last, REF);
    check(gap_max == REF, "R3 max idle spacing", gap_max, REF);
  endtask

  task automatic t_lone_strobe();
    acc_valid = 0;
    @(posedge cpu_clk);
    cpu_cs_n = 1; cpu_as_n = 0; cpu_lds_n = 0; cpu_uds_n = 0;
    repeat (12) @(posedge cpu_clk);
    @(negedge clk);
    check(!acc_valid && dtack_n, "R2 strobe without select", {acc_valid, dtack_n}, 1);
    @(posedge cpu_clk);
    cpu_cs_n = 0; cpu_as_n = 1;
    repeat (12) @(posedge cpu_clk);
    @(negedge clk);
    check(!acc_valid && dtack_n, "R2 select without strobe", {acc_valid, dtack_n}, 1);
    @(posedge cpu_clk);
    cpu_cs_n = 1; cpu_lds_n = 1; cpu_uds_n = 1;
    repeat (3) @(posedge cpu_clk);
  endtask

  task automatic t_access(input logic bank, input logic rw, input logic lds,
                          input logic uds, input logic [22:1] addr, input int hold);
    logic [3:0] exp_cas;
    logic [1:0] exp_we;
    int n;
    exp_cas = 4'hF;
    exp_cas[bank*2]   = lds;
    exp_cas[bank*2+1] = uds;
    exp_we = 2'b11;
    exp_we[bank] = rw;
    acc_valid = 0;
    @(posedge cpu_clk);
    cpu_addr = addr; bank_sel = bank; cpu_rw = rw; cpu_cs_n = 0;
    @(posedge cpu_clk);
    cpu_as_n = 0; cpu_lds_n = lds; cpu_uds_n = uds;
    n = 0;
    while (dtack_n && n < 400) begin @(negedge clk); n++; end
    check(!dtack_n, "R10 acknowledge given", dtack_n, 0);
    check(cas_n == exp_cas, "R9 byte-lane CAS", cas_n, exp_cas);
    check(we_n == exp_we, "R8 write-enable", we_n, exp_we);
    check(ras_n == (bank ? 2'b01 : 2'b10), "R7 selected RAS", ras_n, bank ? 1 : 2);
    repeat (hold) @(posedge cpu_clk);
    @(negedge clk);
    check(!dtack_n, "R10 acknowledge held", dtack_n, 0);
    @(posedge cpu_clk);
    cpu_as_n = 1; cpu_cs_n = 1; cpu_lds_n = 1; cpu_uds_n = 1; cpu_rw = 1;
    n = 0;
    while (!dtack_n && n < 400) begin @(negedge clk); n++; end
    check(ras_n == 2'b11 && cas_n == 4'hF && we_n == 2'b11, "R10 strobes released",
          {ras_n, cas_n, we_n}, 8'hFF);
    check(acc_valid && acc_row == addr[11:1], "R7 row address", acc_row, addr[11:1]);
    check(acc_bank == bank, "R7 bank", acc_bank, bank);
    check(acc_col == addr[22:12], "R8 column address", acc_col, addr[22:12]);
    repeat (2) @(posedge cpu_clk);
  endtask

  task automatic t_directed();
    t_access(0, 1, 0, 0, 22'h2A_5F3C, 2);
    t_access(1, 0, 0, 1, 22'h15_A0C3, 1);
    t_access(1, 1, 1, 0, 22'h3F_FFFF, 4);
    t_access(0, 0, 1, 0, 22'h00_0001, 3);
  endtask

  task automatic t_stress();
    int base;
    base = ref_count;
    for (int i = 0; i < 70; i++) begin
      logic [22:1] a;
      a = 22'(i * 32'h0013_579B + 32'h00AB_CDE1);
      t_access(i[0], i[1], (i % 3) == 2, (i % 3) == 1, a,
               (i % 13 == 0) ? 25 : 1 + i % 7);
    end
    check(ref_count >= base + 2, "R6 refreshes occur under traffic", ref_count - base, 2);
    check(gap_max <= REF + acc_len_max + 8, "R6 refresh spacing bound",
          gap_max, REF + acc_len_max + 8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_refresh_idle();
    t_lone_strobe();
    t_directed();
    t_stress();
    repeat (10) @(negedge clk);
    check(err_r4 == 0, "R4 refresh strobe order", err_r4, 0);
    check(err_r5 == 0, "R5 write-enable at refresh", err_r5, 0);
    check(err_r6 == 0, "R6 refresh/access overlap", err_r6, 0);
    check(err_r11 == 0, "R11 RAS precharge", err_r11, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule